// File: doc/BRIEF.md
# A/D conversion sequencer

This block runs a 12-bit successive-approximation conversion on one of five multiplexed analog inputs. Software writes a control register holding a start bit, a channel field and a read-only end-of-conversion flag, plus a 2-bit register that picks how far the system clock is divided to form the conversion clock. A conversion is launched only when the start bit is raised and then lowered again. The sequencer then latches the channel and divider choice, waits a fixed sampling period, and runs twelve bit trials from the most significant bit down, one per conversion clock.

For each trial the block presents a code to the external DAC. An external comparator reports whether the analog input is at or above that code. When the last bit is decided, the result is written to a high-byte and a low-byte register in the same clock edge. The end-of-conversion flag then clears and a sticky interrupt request is raised.

Top module: `adc_seq_ctrl`

## Requirements
- R1: After reset, ctl_o reads 0x40 (start at bit 7 = 0, end-of-conversion at bit 6 = 1, channel at bits 2:0 = 0, bits 5:3 = 0). sel_o reads 00, both result bytes read 0, irq_o is 0 and trial_o is 0.
- R2: Channel codes 0 to 4 in bits 2:0 are valid. A start sequence with code 5, 6 or 7 starts nothing: the end-of-conversion flag, irq_o and the result bytes keep their values.
- R3: A conversion begins only when a write takes the start bit from 1 to 0. A write that only sets it to 1 starts no conversion.
- R4: The end-of-conversion bit (ctl_o bit 6) becomes 1 on the clock edge after the write that accepts a start. It stays 1 until the result is stored.
- R5: The conversion clock is the system clock divided by 2 << (2*sel), which gives 2, 8, 32 or 128 for sel codes 0 to 3. The code is latched when a conversion starts.
- R6: A conversion lasts 4 sampling conversion clocks plus 12 trial clocks. The end-of-conversion bit reads 0 exactly 16*div+1 system clocks after the accepting write edge.
- R7: trial_o is 0 outside the trial phase. At the first trial it equals 0x800. Each trial sets the bit under test above the bits already decided, with the lower bits at 0. A bit is kept when cmp_i is 1, so the stored result equals the input code for a comparator that reports input >= trial_o.
- R8: res_hi_o carries result bits 11:8 in its bits 3:0, with bits 7:4 at 0. res_lo_o carries result bits 7:0. Both bytes change together at completion and hold at all other times.
- R9: irq_o is set at completion and stays set until irq_clr_i is asserted. A completion in the same cycle as a clear leaves it set.
- R10: A start sequence written while a conversion runs is ignored. Neither the running conversion's channel, its length nor its result changes, and no second conversion follows.
- R11: chan_o presents the channel latched at the start of the conversion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ctl_we_i | input | 1 | Control register write strobe |
| ctl_wdata_i | input | 8 | Control write data: bit 7 start, bits 2:0 channel |
| ctl_o | output | 8 | Control register read value |
| sel_we_i | input | 1 | Clock-select write strobe |
| sel_wdata_i | input | 2 | Clock-select write data |
| sel_o | output | 2 | Clock-select register read value |
| irq_clr_i | input | 1 | Clears the interrupt request |
| irq_o | output | 1 | Conversion-complete interrupt request |
| cmp_i | input | 1 | Comparator decision, 1 when input >= trial_o |
| trial_o | output | 12 | Trial code for the DAC |
| chan_o | output | 3 | Analog multiplexer select |
| res_hi_o | output | 8 | Result high byte |
| res_lo_o | output | 8 | Result low byte |

## Verification
The assertions assume that cmp_i is settled and meaningful during every trial cycle. They also assume that register writes reach the block only as single-cycle strobes that are synchronous to clk_i. The bench derives cmp_i combinationally from a per-channel analog code compared against trial_o and chan_o, so the comparator always answers the current trial. It changes strobes and data only on falling clock edges. The bench sweeps every divider code against every valid channel, and adds the extreme input codes, invalid channels and start sequences written in mid-conversion.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_SAMPLE, ST_CONV} sar_state_e;
  localparam int CTL_START_BIT = 7;
  localparam int CTL_EOC_BIT   = 6;
endpackage

// File: rtl/adc_clk_div.sv
module adc_clk_div #(
  parameter int SEL_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             tick_o
);
  localparam int CNT_W = 2 * ((1 << SEL_W) - 1) + 1;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W:0]   div_full;
  logic [CNT_W-1:0] last_cnt;

  // divisor = 2 << (2*sel)
  assign div_full = {{CNT_W{1'b0}}, 1'b1} << (32'd1 + 32'd2 * 32'(sel_i));
  assign last_cnt = CNT_W'(div_full - 1'b1);
  assign tick_o   = run_i && (cnt_q == last_cnt);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cnt_q <= '0;
    else if (!run_i)   cnt_q <= '0;
    else if (tick_o)   cnt_q <= '0;
    else               cnt_q <= cnt_q + 1'b1;
  end

  // R5
  tick_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> !tick_o);
endmodule

// File: rtl/adc_sar_core.sv
module adc_sar_core
  import adc_seq_pkg::*;
#(
  parameter int RES_W        = 12,
  parameter int SAMPLE_TICKS = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             go_i,
  input  logic             tick_i,
  input  logic             cmp_i,
  output logic             busy_o,
  output logic             done_o,
  output logic [RES_W-1:0] trial_o,
  output logic [RES_W-1:0] result_o
);
  localparam int IDX_W = $clog2(RES_W);
  localparam int PH_W  = (SAMPLE_TICKS > 2) ? $clog2(SAMPLE_TICKS) : 1;

  sar_state_e       state_q;
  logic [PH_W-1:0]  phase_q;
  logic [IDX_W-1:0] bit_q;
  logic [RES_W-1:0] work_q;
  logic [RES_W-1:0] bit_mask;
  logic [RES_W-1:0] low_mask;

  assign bit_mask = {{(RES_W-1){1'b0}}, 1'b1} << bit_q;
  assign low_mask = (bit_mask << 1) - 1'b1;
  assign busy_o   = (state_q != ST_IDLE);
  assign trial_o  = (state_q == ST_CONV) ? (work_q | bit_mask) : '0;
  assign done_o   = (state_q == ST_CONV) && tick_i && (bit_q == '0);
  assign result_o = cmp_i ? (work_q | bit_mask) : work_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      phase_q <= '0;
      bit_q   <= '0;
      work_q  <= '0;
    end else begin
      case (state_q)
        ST_IDLE: if (go_i) begin
          state_q <= ST_SAMPLE;
          phase_q <= '0;
          work_q  <= '0;
        end
        ST_SAMPLE: if (tick_i) begin
          if (phase_q == PH_W'(SAMPLE_TICKS - 1)) begin
            state_q <= ST_CONV;
            bit_q   <= IDX_W'(RES_W - 1);
          end else begin
            phase_q <= phase_q + 1'b1;
          end
        end
        ST_CONV: if (tick_i) begin
          if (cmp_i) work_q <= work_q | bit_mask;
          if (bit_q == '0) state_q <= ST_IDLE;
          else             bit_q   <= bit_q - 1'b1;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // R10
  go_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    go_i |-> (state_q == ST_IDLE));
  // R7
  trial_low_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_CONV) |-> ((work_q & low_mask) == '0));
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_seq_pkg::*;
#(
  parameter int RES_W        = 12,
  parameter int NUM_CH       = 5,
  parameter int CH_W         = 3,
  parameter int SEL_W        = 2,
  parameter int SAMPLE_TICKS = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ctl_we_i,
  input  logic [7:0]       ctl_wdata_i,
  output logic [7:0]       ctl_o,
  input  logic             sel_we_i,
  input  logic [SEL_W-1:0] sel_wdata_i,
  output logic [SEL_W-1:0] sel_o,
  input  logic             irq_clr_i,
  output logic             irq_o,
  input  logic             cmp_i,
  output logic [RES_W-1:0] trial_o,
  output logic [CH_W-1:0]  chan_o,
  output logic [7:0]       res_hi_o,
  output logic [7:0]       res_lo_o
);
  logic             start_q, start_d1_q, eoc_q, irq_q;
  logic [CH_W-1:0]  chan_q, conv_chan_q;
  logic [SEL_W-1:0] sel_q, conv_sel_q;
  logic [RES_W-1:0] res_q;
  logic             fall, chan_ok, go, busy, done, tick;
  logic [RES_W-1:0] final_res;

  assign fall    = start_d1_q & ~start_q;
  assign chan_ok = (chan_q < CH_W'(NUM_CH));
  assign go      = fall & ~busy & chan_ok;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      start_q    <= 1'b0;
      start_d1_q <= 1'b0;
      chan_q     <= '0;
      sel_q      <= '0;
    end else begin
      start_d1_q <= start_q;
      if (ctl_we_i) begin
        start_q <= ctl_wdata_i[CTL_START_BIT];
        chan_q  <= ctl_wdata_i[CH_W-1:0];
      end
      if (sel_we_i) sel_q <= sel_wdata_i;
    end
  end

  // conversion context, status and results
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      eoc_q       <= 1'b1;
      irq_q       <= 1'b0;
      conv_chan_q <= '0;
      conv_sel_q  <= '0;
      res_q       <= '0;
    end else begin
      if (go) begin
        eoc_q       <= 1'b1;
        conv_chan_q <= chan_q;
        conv_sel_q  <= sel_q;
      end
      if (done) begin
        eoc_q <= 1'b0;
        res_q <= final_res;
        irq_q <= 1'b1;
      end else if (irq_clr_i) begin
        irq_q <= 1'b0;
      end
    end
  end

  adc_clk_div #(.SEL_W(SEL_W)) u_div (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (busy),
    .sel_i  (conv_sel_q),
    .tick_o (tick)
  );

  adc_sar_core #(.RES_W(RES_W), .SAMPLE_TICKS(SAMPLE_TICKS)) u_sar (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .go_i     (go),
    .tick_i   (tick),
    .cmp_i    (cmp_i),
    .busy_o   (busy),
    .done_o   (done),
    .trial_o  (trial_o),
    .result_o (final_res)
  );

  assign ctl_o    = {start_q, eoc_q, {(6-CH_W){1'b0}}, chan_q};
  assign sel_o    = sel_q;
  assign irq_o    = irq_q;
  assign chan_o   = conv_chan_q;
  assign res_hi_o = 8'(res_q >> 8);
  assign res_lo_o = res_q[7:0];

  // R4
  eoc_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    go |=> ctl_o[CTL_EOC_BIT]);
  // R9
  done_flags_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done |=> (irq_o && !ctl_o[CTL_EOC_BIT]));
  // R8
  res_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done |=> ($stable(res_hi_o) && $stable(res_lo_o)));
  // R2
  chan_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy |-> (chan_o < CH_W'(NUM_CH)));
  // R7
  idle_trial_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy |-> (trial_o == '0));
endmodule

// File: tb/adc_seq_ctrl_tb.sv
`timescale 1ns/1ps
module adc_seq_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ctl_we = 1'b0;
  logic [7:0]  ctl_wdata = '0;
  logic [7:0]  ctl;
  logic        sel_we = 1'b0;
  logic [1:0]  sel_wdata = '0;
  logic [1:0]  sel;
  logic        irq_clr = 1'b0;
  logic        irq;
  logic        cmp;
  logic [11:0] trial;
  logic [2:0]  chan;
  logic [7:0]  res_hi, res_lo;
  logic [11:0] ana [5];
  int          cyc = 0;
  int          n_chk = 0;
  int          n_fail = 0;

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  assign cmp = (chan < 3'd5) ? (ana[chan] >= trial) : 1'b0;

  adc_seq_ctrl dut_i (
    .clk_i(clk), .rst_ni(rst_n), .ctl_we_i(ctl_we), .ctl_wdata_i(ctl_wdata),
    .ctl_o(ctl), .sel_we_i(sel_we), .sel_wdata_i(sel_wdata), .sel_o(sel),
    .irq_clr_i(irq_clr), .irq_o(irq), .cmp_i(cmp), .trial_o(trial),
    .chan_o(chan), .res_hi_o(res_hi), .res_lo_o(res_lo)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr_ctl(input logic [7:0] d);
    @(negedge clk); ctl_we = 1'b1; ctl_wdata = d;
    @(negedge clk); ctl_we = 1'b0;
  endtask

  task automatic wr_sel(input logic [1:0] d);
    @(negedge clk); sel_we = 1'b1; sel_wdata = d;
    @(negedge clk); sel_we = 1'b0;
  endtask

  task automatic clr_irq();
    @(negedge clk); irq_clr = 1'b1;
    @(negedge clk); irq_clr = 1'b0;
  endtask

  // full conversion with timing, trial and result checks
  task automatic convert(input int ch, input int s, input bit hold_clr);
    int t0, d, dv;
    logic [11:0] res;
    dv = 2 << (2 * s);
    wr_sel(2'(s));
    wr_ctl({1'b1, 4'b0, 3'(ch)});
    wr_ctl({1'b0, 4'b0, 3'(ch)});
    t0 = cyc;
    irq_clr = hold_clr;
    forever begin
      @(negedge clk);
      d = cyc - t0;
      if (d == 1) begin
        chk(ctl[6] == 1'b1, "R4 eoc set after start", int'(ctl[6]), 1);
        chk(chan == 3'(ch), "R11 channel latched", int'(chan), ch);
      end
      if (d == 1 + 4 * dv) chk(trial == 12'h800, "R7 first trial", int'(trial), 'h800);
      if (!ctl[6] || d > 5000) break;
    end
    chk(d == 1 + 16 * dv, "R6 R5 conversion length", d, 1 + 16 * dv);
    res = ana[ch];
    chk(res_hi == {4'b0, res[11:8]}, "R8 high byte", int'(res_hi), int'({4'b0, res[11:8]}));
    chk(res_lo == res[7:0], "R8 R7 low byte", int'(res_lo), int'(res[7:0]));
    chk(irq == 1'b1, "R9 irq set", int'(irq), 1);
    if (hold_clr) begin
      @(negedge clk); irq_clr = 1'b0;
      chk(irq == 1'b0, "R9 clear after completion", int'(irq), 0);
    end else begin
      clr_irq();
      chk(irq == 1'b0, "R9 irq cleared", int'(irq), 0);
    end
  endtask

  initial begin
    #1200000;
    n_fail++; n_chk++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [7:0] h0, l0;
    int t0;
    for (int i = 0; i < 5; i++) ana[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(ctl == 8'h40, "R1 control reset", int'(ctl), 'h40);
    chk(sel == 2'b00, "R1 clock select reset", int'(sel), 0);
    chk({res_hi, res_lo} == 16'h0, "R1 results reset", int'({res_hi, res_lo}), 0);
    chk(irq == 1'b0, "R1 irq reset", int'(irq), 0);
    chk(trial == 12'h0, "R1 trial reset", int'(trial), 0);

    // R3: raising start alone does nothing
    ana[0] = 12'h3c7;
    wr_ctl(8'h80);
    repeat (60) @(negedge clk);
    chk(irq == 1'b0, "R3 no completion on rising edge", int'(irq), 0);
    chk(trial == 12'h0, "R3 no trials on rising edge", int'(trial), 0);

    // sweep every divider code against every channel
    for (int s = 0; s < 4; s++) begin
      for (int ch = 0; ch < 5; ch++) begin
        for (int k = 0; k < 5; k++) ana[k] = 12'((k * 819 + s * 1237 + 5 + ch * 311) % 4096);
        convert(ch, s, 1'b0);
      end
    end

    // extreme codes
    ana[4] = 12'hfff; convert(4, 0, 1'b0);
    ana[0] = 12'h000; convert(0, 1, 1'b0);
    ana[2] = 12'h800; convert(2, 0, 1'b0);
    ana[3] = 12'h7ff; convert(3, 0, 1'b1);

    // R2: invalid channels
    h0 = res_hi; l0 = res_lo;
    for (int c = 5; c < 8; c++) begin
      wr_ctl({1'b1, 4'b0, 3'(c)});
      wr_ctl({1'b0, 4'b0, 3'(c)});
      repeat (40) @(negedge clk);
      chk(ctl[6] == 1'b0, "R2 invalid channel eoc", int'(ctl[6]), 0);
      chk(irq == 1'b0, "R2 invalid channel irq", int'(irq), 0);
      chk({res_hi, res_lo} == {h0, l0}, "R2 invalid channel result", int'({res_hi, res_lo}), int'({h0, l0}));
    end

    // R10: start sequence during a running conversion
    ana[1] = 12'h5a5; ana[3] = 12'h123;
    wr_sel(2'd0);
    wr_ctl(8'h81);
    wr_ctl(8'h01);
    t0 = cyc;
    wr_sel(2'd3);
    wr_ctl(8'h83);
    wr_ctl(8'h03);
    while (ctl[6] && (cyc - t0) < 5000) @(negedge clk);
    chk(cyc - t0 == 33, "R10 length unchanged", cyc - t0, 33);
    chk({res_hi, res_lo} == 16'h05a5, "R10 result from first channel", int'({res_hi, res_lo}), 'h5a5);
    clr_irq();
    repeat (300) @(negedge clk);
    chk(ctl[6] == 1'b0, "R10 no second conversion eoc", int'(ctl[6]), 0);
    chk(irq == 1'b0, "R10 no second conversion irq", int'(irq), 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule